// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Router

This block sits beside a 32-line GPIO bank and turns its input state and edge events into interrupt requests aimed at individual processors. Every processor gets private copies of an edge-cause register, an edge-enable mask and a level-enable mask. It therefore sees only the GPIO interrupts it has enabled, and it acknowledges them without disturbing the others. The GPIO core keeps pin I/O, direction and polarity. It hands this block two inputs: the polarity-corrected line state (`level_in`) and single-cycle edge event pulses (`edge_evt`).

For each processor and each group of eight lines, one summary output is driven. The output is the OR, over the eight lines, of the level source (line state AND level mask) and the edge source (captured cause AND edge mask). A parameter selects one of two register layouts. The first is a four-processor layout in which each processor has its own cause register. The second is a two-processor layout in which both processors share one cause register and only the masks are private.

Registers are reached through a simple synchronous write strobe and a registered read port that follows the address.

Top module: `gpir_percpu_router`

## Requirements
- R1: After reset, every cause and mask register reads zero and every summary output is low.
- R2: In the per-processor-cause layout (PER_CPU_CAUSE=1), processor n (n < 4) has its cause register at byte offset 4·n, its edge mask at 0x10+4·n and its level mask at 0x20+4·n. All three can be written and read back.
- R3: In the shared-cause layout (PER_CPU_CAUSE=0), the single shared cause register is at 0x14. Processor 0's edge and level masks are at 0x18 and 0x1C. Processor 1's edge and level masks are at 0x30 and 0x34.
- R4: A 1 on bit i of `edge_evt` in a cycle sets bit i of every cause register at that clock edge.
- R5: A write to a cause register clears the bits written as 0 and keeps the bits written as 1. It affects only the processor addressed; other processors' cause registers keep their pending bits. An edge event arriving in the same cycle as a clearing write leaves the bit set.
- R6: For each processor, a line's source is (`level_in` AND level mask) OR (cause AND edge mask). A processor whose two masks are both zero raises no summary output.
- R7: Summary output `irq_out[c*4+g]` is the OR of processor c's sources for lines 8·g to 8·g+7. It is registered, so it reflects the register state and `level_in` of the previous cycle.
- R8: Reads of an offset that no register occupies, including offsets whose two low bits are not zero, return zero. Writes to such offsets change no register.
- R9: `reg_rdata` shows, one clock after `reg_addr` is applied, the value the addressed register held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the per-processor window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| level_in | input | 32 | Polarity-corrected line state from the GPIO core |
| edge_evt | input | 32 | One-cycle edge event pulses from the GPIO core |
| irq_out | output | 16 | Summary interrupts, processor c group g at index c*4+g (8 bits wide in the shared-cause layout) |

## Verification
The bench builds two copies side by side from the same line stimulus. One uses the default four-processor layout with private cause registers; the other uses the shared-cause two-processor layout. Between them, both address maps, cross-processor isolation of acknowledges, and a single acknowledge that clears the shared cause for both processors are all within reach. Random writes, including writes to unmapped and misaligned offsets, run together with sparse edge pulses and changing line levels. Directed cases cover an edge arriving during a clearing write and a processor whose masks are all zero.

// File: rtl/gpir_pkg.sv
package gpir_pkg;

  typedef enum logic [1:0] {FLD_NONE, FLD_CAUSE, FLD_EMASK, FLD_LMASK} fld_e;

  typedef struct packed {
    fld_e       fld;
    logic [1:0] cpu;
  } hit_t;

  // Decode a byte offset into the register it selects.
  function automatic hit_t map_addr(input logic [7:0] a, input bit per_cpu, input int ncpu);
    hit_t h;
    h.fld = FLD_NONE;
    h.cpu = 2'd0;
    if (a[1:0] == 2'b00) begin
      if (per_cpu) begin
        if (a < 8'h30 && int'(a[3:2]) < ncpu) begin
          h.cpu = a[3:2];
          case (a[5:4])
            2'd0:    h.fld = FLD_CAUSE;
            2'd1:    h.fld = FLD_EMASK;
            default: h.fld = FLD_LMASK;
          endcase
        end
      end else begin
        case (a)
          8'h14: h.fld = FLD_CAUSE;
          8'h18: h.fld = FLD_EMASK;
          8'h1C: h.fld = FLD_LMASK;
          8'h30: begin h.fld = FLD_EMASK; h.cpu = 2'd1; end
          8'h34: begin h.fld = FLD_LMASK; h.cpu = 2'd1; end
          default: h.fld = FLD_NONE;
        endcase
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/gpir_cause_reg.sv
module gpir_cause_reg #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_wr,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] evt,
  output logic [LINES-1:0] cause
);
  logic [LINES-1:0] keep;

  // A clearing write keeps only the bits written as 1.
  assign keep = clr_wr ? wdata : {LINES{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cause <= '0;
    else     cause <= (cause & keep) | evt;
  end
endmodule

// File: rtl/gpir_slice.sv
module gpir_slice #(
  parameter int LINES     = 32,
  parameter int GRP       = 8,
  parameter bit OWN_CAUSE = 1'b1,
  localparam int NGRP     = LINES / GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cause_wr,
  input  logic             em_wr,
  input  logic             lm_wr,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] evt,
  input  logic [LINES-1:0] level_in,
  input  logic [LINES-1:0] ext_cause,
  output logic [LINES-1:0] cause_o,
  output logic [LINES-1:0] emask_o,
  output logic [LINES-1:0] lmask_o,
  output logic [NGRP-1:0]  irq_o
);
  logic [LINES-1:0] src;

  generate
    if (OWN_CAUSE) begin : g_own
      logic [LINES-1:0] unused_ext;
      assign unused_ext = ext_cause;
      gpir_cause_reg #(.LINES(LINES)) u_cause (
        .clk(clk), .rst(rst), .clr_wr(cause_wr), .wdata(wdata),
        .evt(evt), .cause(cause_o)
      );
    end else begin : g_ext
      logic unused_sink;
      assign unused_sink = cause_wr ^ (^evt);
      assign cause_o = ext_cause;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      emask_o <= '0;
      lmask_o <= '0;
    end else begin
      if (em_wr) emask_o <= wdata;
      if (lm_wr) lmask_o <= wdata;
    end
  end

  assign src = (level_in & lmask_o) | (cause_o & emask_o);

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (rst) irq_o[g] <= 1'b0;
        else     irq_o[g] <= |src[g*GRP +: GRP];
      end
    end
  endgenerate
endmodule

// File: rtl/gpir_percpu_router.sv
module gpir_percpu_router #(
  parameter int LINES         = 32,
  parameter int GRP           = 8,
  parameter int MAX_CPUS      = 4,
  parameter bit PER_CPU_CAUSE = 1'b1,
  localparam int NCPU         = PER_CPU_CAUSE ? MAX_CPUS : 2,
  localparam int NGRP         = LINES / GRP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [7:0]             reg_addr,
  input  logic [LINES-1:0]       reg_wdata,
  output logic [LINES-1:0]       reg_rdata,
  input  logic [LINES-1:0]       level_in,
  input  logic [LINES-1:0]       edge_evt,
  output logic [NCPU*NGRP-1:0]   irq_out
);
  import gpir_pkg::*;

  hit_t                  hit;
  logic [LINES-1:0]      shared_cause;
  logic [NCPU*LINES-1:0] cause_all;
  logic [NCPU*LINES-1:0] emask_all;
  logic [NCPU*LINES-1:0] lmask_all;
  logic [LINES-1:0]      rd_next;

  assign hit = map_addr(reg_addr, PER_CPU_CAUSE, NCPU);

  generate
    if (!PER_CPU_CAUSE) begin : g_shared
      gpir_cause_reg #(.LINES(LINES)) u_shared (
        .clk(clk), .rst(rst),
        .clr_wr(reg_wr && hit.fld == FLD_CAUSE),
        .wdata(reg_wdata), .evt(edge_evt), .cause(shared_cause)
      );
    end else begin : g_noshared
      assign shared_cause = '0;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic sel;
      assign sel = reg_wr && (hit.cpu == 2'(c));
      gpir_slice #(.LINES(LINES), .GRP(GRP), .OWN_CAUSE(PER_CPU_CAUSE)) u_slice (
        .clk(clk), .rst(rst),
        .cause_wr(sel && hit.fld == FLD_CAUSE),
        .em_wr(sel && hit.fld == FLD_EMASK),
        .lm_wr(sel && hit.fld == FLD_LMASK),
        .wdata(reg_wdata), .evt(edge_evt), .level_in(level_in),
        .ext_cause(shared_cause),
        .cause_o(cause_all[c*LINES +: LINES]),
        .emask_o(emask_all[c*LINES +: LINES]),
        .lmask_o(lmask_all[c*LINES +: LINES]),
        .irq_o(irq_out[c*NGRP +: NGRP])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    case (hit.fld)
      FLD_CAUSE: rd_next = cause_all[int'(hit.cpu)*LINES +: LINES];
      FLD_EMASK: rd_next = emask_all[int'(hit.cpu)*LINES +: LINES];
      FLD_LMASK: rd_next = lmask_all[int'(hit.cpu)*LINES +: LINES];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/gpir_percpu_router_chk.sv
module gpir_percpu_router_chk #(
  parameter int LINES         = 32,
  parameter int GRP           = 8,
  parameter int NCPU          = 4,
  parameter bit PER_CPU_CAUSE = 1'b1,
  localparam int NGRP         = LINES / GRP
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic [7:0]            reg_addr,
  input logic [LINES-1:0]      edge_evt,
  input logic [NCPU*NGRP-1:0]  irq_out,
  input logic [NCPU*LINES-1:0] cause_all,
  input logic [NCPU*LINES-1:0] emask_all,
  input logic [NCPU*LINES-1:0] lmask_all
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0); // R1

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr >= 8'h40) |=> ($stable(emask_all) && $stable(lmask_all))); // R8

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_c
      AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (|edge_evt) |=> ((cause_all[c*LINES +: LINES] & $past(edge_evt)) == $past(edge_evt))); // R4

      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (emask_all[c*LINES +: LINES] == '0 && lmask_all[c*LINES +: LINES] == '0)
          |=> irq_out[c*NGRP +: NGRP] == '0); // R6

      if (PER_CPU_CAUSE) begin : g_iso
        AST_CAUSE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
          !(reg_wr && reg_addr == 8'(4*c)) |=>
            ((cause_all[c*LINES +: LINES] & $past(cause_all[c*LINES +: LINES]))
              == $past(cause_all[c*LINES +: LINES]))); // R5
      end
    end
  endgenerate
endmodule

bind gpir_percpu_router gpir_percpu_router_chk #(
  .LINES(LINES), .GRP(GRP), .NCPU(NCPU), .PER_CPU_CAUSE(PER_CPU_CAUSE)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .edge_evt(edge_evt), .irq_out(irq_out),
  .cause_all(cause_all), .emask_all(emask_all), .lmask_all(lmask_all)
);

// File: tb/gpir_percpu_router_test.sv
module gpir_percpu_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        p_wr = 1'b0, s_wr = 1'b0;
  logic [7:0]  p_addr = '0, s_addr = '0;
  logic [31:0] p_wdata = '0, s_wdata = '0;
  logic [31:0] p_rdata, s_rdata;
  logic [31:0] lvl = '0, evt = '0;
  logic [15:0] p_irq;
  logic [7:0]  s_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_c [4];
  logic [31:0] m_e [4];
  logic [31:0] m_l [4];
  logic [31:0] s_c;
  logic [31:0] s_e [2];
  logic [31:0] s_l [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpir_percpu_router #(.PER_CPU_CAUSE(1'b1)) uut (
    .clk(clk), .rst(rst), .reg_wr(p_wr), .reg_addr(p_addr), .reg_wdata(p_wdata),
    .reg_rdata(p_rdata), .level_in(lvl), .edge_evt(evt), .irq_out(p_irq)
  );

  gpir_percpu_router #(.PER_CPU_CAUSE(1'b0)) uut_sh (
    .clk(clk), .rst(rst), .reg_wr(s_wr), .reg_addr(s_addr), .reg_wdata(s_wdata),
    .reg_rdata(s_rdata), .level_in(lvl), .edge_evt(evt), .irq_out(s_irq)
  );

  // kind: 0 none, 1 cause, 2 edge mask, 3 level mask (R2, R8)
  function automatic int p_kind(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h30) return 0;
    return int'(a[5:4]) + 1;
  endfunction

  // R3 layout
  function automatic int s_kind(input logic [7:0] a, output int cpu);
    cpu = 0;
    case (a)
      8'h14: return 1;
      8'h18: return 2;
      8'h1C: return 3;
      8'h30: begin cpu = 1; return 2; end
      8'h34: begin cpu = 1; return 3; end
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] p_read(input logic [7:0] a);
    int c;
    c = int'(a[3:2]);
    case (p_kind(a))
      1: return m_c[c];
      2: return m_e[c];
      3: return m_l[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] s_read(input logic [7:0] a);
    int c, k;
    k = s_kind(a, c);
    case (k)
      1: return s_c;
      2: return s_e[c];
      3: return s_l[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] p_exp_irq();
    logic [15:0] r;
    logic [31:0] src;
    r = '0;
    for (int c = 0; c < 4; c++) begin
      src = (lvl & m_l[c]) | (m_c[c] & m_e[c]);
      for (int g = 0; g < 4; g++) r[c*4+g] = |src[g*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [7:0] s_exp_irq();
    logic [7:0] r;
    logic [31:0] src;
    r = '0;
    for (int c = 0; c < 2; c++) begin
      src = (lvl & s_l[c]) | (s_c & s_e[c]);
      for (int g = 0; g < 4; g++) r[c*4+g] = |src[g*8 +: 8];
    end
    return r;
  endfunction

  task automatic update_models();
    int c, k;
    for (int i = 0; i < 4; i++) begin
      if (p_wr && p_kind(p_addr) == 1 && int'(p_addr[3:2]) == i) m_c[i] = m_c[i] & p_wdata;
      m_c[i] = m_c[i] | evt;
    end
    if (p_wr && p_kind(p_addr) == 2) m_e[int'(p_addr[3:2])] = p_wdata;
    if (p_wr && p_kind(p_addr) == 3) m_l[int'(p_addr[3:2])] = p_wdata;
    k = s_kind(s_addr, c);
    if (s_wr && k == 1) s_c = s_c & s_wdata;
    s_c = s_c | evt;
    if (s_wr && k == 2) s_e[c] = s_wdata;
    if (s_wr && k == 3) s_l[c] = s_wdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: expectations from the pre-edge model, compared at the next falling edge.
  task automatic cycle(input string trd, input string tirq);
    logic [15:0] ei;
    logic [7:0]  eis;
    logic [31:0] er, ers;
    ei  = p_exp_irq();
    eis = s_exp_irq();
    er  = p_read(p_addr);
    ers = s_read(s_addr);
    @(posedge clk);
    update_models();
    @(negedge clk);
    chk({trd, " rdata (4-cpu)"}, p_rdata, er);
    chk({trd, " rdata (shared)"}, s_rdata, ers);
    chk({tirq, " irq (4-cpu)"}, {16'h0, p_irq}, {16'h0, ei});
    chk({tirq, " irq (shared)"}, {24'h0, s_irq}, {24'h0, eis});
  endtask

  task automatic idle();
    p_wr = 1'b0; s_wr = 1'b0; evt = '0;
  endtask

  task automatic pwrite(input logic [7:0] a, input logic [31:0] d, input string t);
    p_wr = 1'b1; p_addr = a; p_wdata = d;
    cycle(t, "R7");
    idle();
  endtask

  task automatic swrite(input logic [7:0] a, input logic [31:0] d, input string t);
    s_wr = 1'b1; s_addr = a; s_wdata = d;
    cycle(t, "R7");
    idle();
  endtask

  task automatic pread(input logic [7:0] a, input string t);
    p_addr = a; cycle(t, "R7");
  endtask

  task automatic sread(input logic [7:0] a, input string t);
    s_addr = a; cycle(t, "R7");
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_c[i] = '0; m_e[i] = '0; m_l[i] = '0; end
    s_c = '0;
    for (int i = 0; i < 2; i++) begin s_e[i] = '0; s_l[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every mapped register and of the outputs
    for (int a = 0; a < 12; a++) begin
      p_addr = 8'(a*4);
      s_addr = (a < 5) ? 8'(8'h14 + a*4) : 8'h30;
      cycle("R1", "R1");
    end

    // R2: per-processor-cause layout
    pwrite(8'h18, 32'hA5A5_0001, "R2");
    pwrite(8'h2C, 32'h0F00_00F0, "R2");
    pread(8'h18, "R2");
    pread(8'h2C, "R2");
    pread(8'h1C, "R2");

    // R3: shared-cause layout
    swrite(8'h18, 32'h0000_00FF, "R3");
    swrite(8'h30, 32'h00FF_0000, "R3");
    swrite(8'h1C, 32'h1234_5678, "R3");
    swrite(8'h34, 32'h8765_4321, "R3");
    sread(8'h30, "R3");
    sread(8'h34, "R3");
    sread(8'h1C, "R3");

    // R4: one edge sets every processor's cause
    evt = 32'h8000_0101;
    cycle("R4", "R4");
    idle();
    for (int c = 0; c < 4; c++) pread(8'(c*4), "R4");
    sread(8'h14, "R4");

    // R5: clearing one processor's cause leaves the others pending
    pwrite(8'h04, ~32'h0000_0001, "R5");
    pread(8'h04, "R5");
    pread(8'h00, "R5");
    pread(8'h08, "R5");
    // R5: edge during a clearing write wins
    evt = 32'h0000_0100;
    pwrite(8'h00, 32'h0, "R5");
    pread(8'h00, "R5");
    // R5: shared acknowledge clears for both processors
    swrite(8'h14, 32'h0, "R5");
    sread(8'h14, "R5");

    // R6: level source and edge source through masks
    pwrite(8'h24, 32'h0000_0100, "R6");
    lvl = 32'h0000_0100;
    cycle("R6", "R6");
    cycle("R6", "R6");
    pwrite(8'h10, 32'h8000_0000, "R6");
    cycle("R6", "R6");
    lvl = '0;
    cycle("R6", "R6");

    // R8: unmapped and misaligned offsets
    pwrite(8'h40, 32'hFFFF_FFFF, "R8");
    pwrite(8'h11, 32'hFFFF_FFFF, "R8");
    swrite(8'h20, 32'hFFFF_FFFF, "R8");
    swrite(8'h00, 32'hFFFF_FFFF, "R8");
    pread(8'h3C, "R8");
    pread(8'h11, "R8");
    sread(8'h10, "R8");
    pread(8'h10, "R8");
    sread(8'h18, "R8");

    // R7/R9: random traffic
    for (int n = 0; n < 600; n++) begin
      p_wr = ($urandom % 3) == 0;
      s_wr = ($urandom % 3) == 0;
      p_addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'(($urandom % 12) * 4);
      case ($urandom % 6)
        0: s_addr = 8'h14;
        1: s_addr = 8'h18;
        2: s_addr = 8'h1C;
        3: s_addr = 8'h30;
        4: s_addr = 8'h34;
        default: s_addr = 8'($urandom);
      endcase
      p_wdata = (($urandom % 2) == 0) ? ~(32'h1 << ($urandom % 32)) : $urandom;
      s_wdata = (($urandom % 2) == 0) ? ~(32'h1 << ($urandom % 32)) : $urandom;
      evt = $urandom & $urandom & $urandom;
      if (($urandom % 8) == 0) lvl = $urandom & $urandom;
      cycle("R9", "R7");
    end
    idle();
    cycle("R9", "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule